// File: doc/BRIEF.md
# Sticky Limit-Status Interrupt Controller

This block sits behind a hardware monitor that converts several analog and tachometer channels one after another. Each finished conversion arrives as a channel index, a value and a one-cycle valid strobe. The block compares the value with limits programmed through a small register port and records any violation in sticky status bits. It also watches six external fault flags. Each flag sets its own sticky bit while it is high.

Software can poll two status registers. It can also wait for the active-low alert output, which stays asserted while any status bit is set and not masked. Reading a status register clears only those bits whose cause has gone away. A bit whose channel is still out of limit, or whose fault flag is still high, survives the read. Bit 7 of the first status register summarises the second register, so software only has to read the second register when that bit is 1.

Top module: `limit_alert_ctrl`

## Requirements
- R1: For analog channels 0..4 (AIN1, AIN2, supply, remote temperature, local temperature), only `meas_val[7:0]` is compared. The channel is out of limit when that byte is strictly greater than its high limit. For fan channels 5 and 6, the full 16-bit value is out of limit when it is strictly greater than the 16-bit fan limit.
- R2: An analog channel is also out of limit when its byte is less than or equal to its low limit.
- R3: Fan f has a low-byte register at 0x10+2f and a high-byte register at 0x11+2f. A low-byte write goes only into a hidden shadow. The comparison limit and the low-byte readback change only when the high byte is written, and then they take {high byte, shadow} together. Both bytes reset to 0xFF.
- R4: A status bit is set by an out-of-limit result (or by a high fault flag) and stays 1 after the condition ends, until a read clears it.
- R5: A read of status A (0x00) or status B (0x01) returns the value held before the read. The read then clears only the bits whose most recent comparison was within limits, or whose fault flag is low in that cycle.
- R6: In status A, measured channel k sits at bit 6-k. Bit 7 reads 1 exactly when any status B bit is set. A measurement with channel index 7 changes nothing.
- R7: `fault_in[j]` (j = 0..5) sets status B bit j. Status B bits 7:6 always read 0.
- R8: Mask A (0x02) uses the same bit positions as status A bits 6:0, and mask B (0x03) uses those of status B bits 5:0. A masked source still sets its status bit but does not assert `alert_n`.
- R9: `alert_n` is 0 exactly while some unmasked status bit is 1. It returns to 1 once reads have cleared every unmasked bit, even if other unmasked-but-cleared sources were set earlier.
- R10: If a violation or fault arrives in the same cycle as a read of its status register, the bit ends at 1.
- R11: After reset, status A and B read 0, both masks read 0, `alert_n` is 1, the analog high limits (0x04+2k) read 0xFF and the analog low limits (0x05+2k) read 0x00. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; triggers clear-on-read for status addresses |
| addr | input | 5 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr`, combinational |
| meas_valid | input | 1 | Measurement result strobe |
| meas_ch | input | 3 | Channel index of the result |
| meas_val | input | 16 | Measured value |
| fault_in | input | 6 | External fault flags, active high |
| alert_n | output | 1 | Active-low interrupt |

## Verification
The hardest cases to reach are the two ways a read can be refused. In the first, the read lands while the fault is still present. In the second, a new violation coincides with the read strobe in the same cycle. The bench handles both by re-measuring the channel out of limit and reading right after, and by driving the read and the violating measurement in the same half-cycle. It then confirms through later reads that the bit survived. Only after an in-limit measurement does a read clear the bit. The bench shows this for every boundary value of every channel, with channel 0 swept over all 256 byte values.

// File: rtl/limstat_pkg.sv
package limstat_pkg;
  localparam int unsigned CMP_W       = 16;
  localparam int unsigned ADR_STAT_A  = 0;
  localparam int unsigned ADR_STAT_B  = 1;
  localparam int unsigned ADR_MASK_A  = 2;
  localparam int unsigned ADR_MASK_B  = 3;
  localparam int unsigned ADR_ANA     = 4;   // pairs: high, low
  localparam int unsigned ADR_FAN     = 16;  // pairs: low byte, high byte

  function automatic logic exceeds_high(input logic [CMP_W-1:0] v,
                                        input logic [CMP_W-1:0] lim);
    return v > lim;
  endfunction

  function automatic logic reaches_low(input logic [CMP_W-1:0] v,
                                       input logic [CMP_W-1:0] lim);
    return v <= lim;
  endfunction
endpackage

// File: rtl/lim_regs.sv
module lim_regs
  import limstat_pkg::*;
#(
  parameter int unsigned N_ANA  = 5,
  parameter int unsigned N_FAN  = 2,
  parameter int unsigned N_EXT  = 6,
  parameter int unsigned ANA_W  = 8,
  parameter int unsigned FAN_W  = 16,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [ADDR_W-1:0]                addr,
  input  logic [DATA_W-1:0]                wr_data,
  output logic [N_ANA-1:0][ANA_W-1:0]      ana_hi,
  output logic [N_ANA-1:0][ANA_W-1:0]      ana_lo,
  output logic [N_FAN-1:0][FAN_W-1:0]      fan_lim,
  output logic [N_FAN-1:0]                 fan_commit,
  output logic [N_ANA+N_FAN-1:0]           mask_a,
  output logic [N_EXT-1:0]                 mask_b
);
  localparam int unsigned N_MEAS = N_ANA + N_FAN;
  localparam int unsigned HI_W   = FAN_W - DATA_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_a <= '0;
      mask_b <= '0;
    end else if (wr_en) begin
      if (addr == ADDR_W'(ADR_MASK_A)) mask_a <= wr_data[N_MEAS-1:0];
      if (addr == ADDR_W'(ADR_MASK_B)) mask_b <= wr_data[N_EXT-1:0];
    end
  end

  for (genvar k = 0; k < N_ANA; k++) begin : g_ana
    localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(ADR_ANA + 2*k);
    localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(ADR_ANA + 2*k + 1);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ana_hi[k] <= '1;
        ana_lo[k] <= '0;
      end else if (wr_en) begin
        if (addr == A_HI) ana_hi[k] <= wr_data[ANA_W-1:0];
        if (addr == A_LO) ana_lo[k] <= wr_data[ANA_W-1:0];
      end
    end
  end

  for (genvar f = 0; f < N_FAN; f++) begin : g_fan
    localparam logic [ADDR_W-1:0] A_LB = ADDR_W'(ADR_FAN + 2*f);
    localparam logic [ADDR_W-1:0] A_HB = ADDR_W'(ADR_FAN + 2*f + 1);
    logic [DATA_W-1:0] shadow_q;
    logic              lo_wr;
    assign lo_wr         = wr_en && (addr == A_LB);
    assign fan_commit[f] = wr_en && (addr == A_HB);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow_q   <= '1;
        fan_lim[f] <= '1;
      end else begin
        if (lo_wr)         shadow_q   <= wr_data;
        if (fan_commit[f]) fan_lim[f] <= {wr_data[HI_W-1:0], shadow_q};
      end
    end
  end
endmodule

// File: rtl/lim_compare.sv
module lim_compare
  import limstat_pkg::*;
#(
  parameter int unsigned N_ANA = 5,
  parameter int unsigned N_FAN = 2,
  parameter int unsigned ANA_W = 8,
  parameter int unsigned FAN_W = 16,
  parameter int unsigned CH_W  = 3
) (
  input  logic                         valid,
  input  logic [CH_W-1:0]              ch,
  input  logic [FAN_W-1:0]             val,
  input  logic [N_ANA-1:0][ANA_W-1:0]  ana_hi,
  input  logic [N_ANA-1:0][ANA_W-1:0]  ana_lo,
  input  logic [N_FAN-1:0][FAN_W-1:0]  fan_lim,
  output logic [N_ANA+N_FAN-1:0]       upd,
  output logic [N_ANA+N_FAN-1:0]       hit
);
  logic [CMP_W-1:0] ana_v;
  logic [CMP_W-1:0] fan_v;
  assign ana_v = CMP_W'(val[ANA_W-1:0]);
  assign fan_v = CMP_W'(val);

  for (genvar k = 0; k < N_ANA; k++) begin : g_ana
    logic sel;
    assign sel    = valid && (ch == CH_W'(k));
    assign upd[k] = sel;
    assign hit[k] = sel && (exceeds_high(ana_v, CMP_W'(ana_hi[k])) ||
                            reaches_low(ana_v, CMP_W'(ana_lo[k])));
  end

  for (genvar f = 0; f < N_FAN; f++) begin : g_fan
    logic sel;
    assign sel            = valid && (ch == CH_W'(N_ANA + f));
    assign upd[N_ANA + f] = sel;
    assign hit[N_ANA + f] = sel && exceeds_high(fan_v, CMP_W'(fan_lim[f]));
  end
endmodule

// File: rtl/sticky_bank.sv
module sticky_bank #(
  parameter int unsigned W        = 7,
  parameter bit          TRACK_LAST = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] upd,
  input  logic [W-1:0] hit,
  input  logic         clr,
  output logic [W-1:0] st_q
);
  logic [W-1:0] live_nx;

  if (TRACK_LAST) begin : g_track
    logic [W-1:0] live_q;
    assign live_nx = (upd & hit) | (~upd & live_q);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live_q <= '0;
      else        live_q <= live_nx;
    end
  end else begin : g_level
    logic [W-1:0] upd_unused;
    assign upd_unused = upd;
    assign live_nx    = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= hit | (st_q & (~{W{clr}} | live_nx));
  end
endmodule

// File: rtl/limit_alert_ctrl.sv
module limit_alert_ctrl
  import limstat_pkg::*;
#(
  parameter int unsigned N_ANA  = 5,
  parameter int unsigned N_FAN  = 2,
  parameter int unsigned N_EXT  = 6,
  parameter int unsigned ANA_W  = 8,
  parameter int unsigned FAN_W  = 16,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              meas_valid,
  input  logic [2:0]        meas_ch,
  input  logic [FAN_W-1:0]  meas_val,
  input  logic [N_EXT-1:0]  fault_in,
  output logic              alert_n
);
  localparam int unsigned N_MEAS = N_ANA + N_FAN;
  localparam int unsigned CH_W   = 3;

  logic [N_ANA-1:0][ANA_W-1:0] ana_hi, ana_lo;
  logic [N_FAN-1:0][FAN_W-1:0] fan_lim;
  logic [N_FAN-1:0]            fan_commit;
  logic [N_MEAS-1:0]           mask_a;
  logic [N_EXT-1:0]            mask_b;
  logic [N_MEAS-1:0]           upd_meas, hit_meas, st_meas, mask_meas;
  logic [N_EXT-1:0]            st_ext;
  logic                        rd_a_ev, rd_b_ev, unmasked_any;
  logic [DATA_W-1:0]           stat_a, stat_b;

  assign rd_a_ev = rd_en && (addr == ADDR_W'(ADR_STAT_A));
  assign rd_b_ev = rd_en && (addr == ADDR_W'(ADR_STAT_B));

  lim_regs #(.N_ANA(N_ANA), .N_FAN(N_FAN), .N_EXT(N_EXT), .ANA_W(ANA_W),
             .FAN_W(FAN_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .ana_hi(ana_hi), .ana_lo(ana_lo), .fan_lim(fan_lim),
    .fan_commit(fan_commit), .mask_a(mask_a), .mask_b(mask_b));

  lim_compare #(.N_ANA(N_ANA), .N_FAN(N_FAN), .ANA_W(ANA_W), .FAN_W(FAN_W),
                .CH_W(CH_W)) u_cmp (
    .valid(meas_valid), .ch(meas_ch), .val(meas_val), .ana_hi(ana_hi),
    .ana_lo(ana_lo), .fan_lim(fan_lim), .upd(upd_meas), .hit(hit_meas));

  sticky_bank #(.W(N_MEAS), .TRACK_LAST(1'b1)) u_st_meas (
    .clk(clk), .rst_n(rst_n), .upd(upd_meas), .hit(hit_meas),
    .clr(rd_a_ev), .st_q(st_meas));

  sticky_bank #(.W(N_EXT), .TRACK_LAST(1'b0)) u_st_ext (
    .clk(clk), .rst_n(rst_n), .upd({N_EXT{1'b1}}), .hit(fault_in),
    .clr(rd_b_ev), .st_q(st_ext));

  // channel k lives at register bit N_MEAS-1-k
  always_comb begin
    stat_a         = '0;
    stat_a[N_MEAS] = |st_ext;
    for (int k = 0; k < N_MEAS; k++) begin
      stat_a[N_MEAS-1-k] = st_meas[k];
      mask_meas[k]       = mask_a[N_MEAS-1-k];
    end
    stat_b = DATA_W'(st_ext);
  end

  assign unmasked_any = (|(st_meas & ~mask_meas)) || (|(st_ext & ~mask_b));
  assign alert_n      = ~unmasked_any;

  always_comb begin
    rd_data = '0;
    if (addr == ADDR_W'(ADR_STAT_A)) rd_data = stat_a;
    if (addr == ADDR_W'(ADR_STAT_B)) rd_data = stat_b;
    if (addr == ADDR_W'(ADR_MASK_A)) rd_data = DATA_W'(mask_a);
    if (addr == ADDR_W'(ADR_MASK_B)) rd_data = DATA_W'(mask_b);
    for (int k = 0; k < N_ANA; k++) begin
      if (addr == ADDR_W'(ADR_ANA + 2*k))     rd_data = DATA_W'(ana_hi[k]);
      if (addr == ADDR_W'(ADR_ANA + 2*k + 1)) rd_data = DATA_W'(ana_lo[k]);
    end
    for (int f = 0; f < N_FAN; f++) begin
      if (addr == ADDR_W'(ADR_FAN + 2*f))     rd_data = fan_lim[f][DATA_W-1:0];
      if (addr == ADDR_W'(ADR_FAN + 2*f + 1)) rd_data = fan_lim[f][FAN_W-1:DATA_W];
    end
  end
endmodule

// File: rtl/limit_alert_chk.sv
module limit_alert_chk
  import limstat_pkg::*;
#(
  parameter int unsigned N_MEAS = 7,
  parameter int unsigned N_EXT  = 6,
  parameter int unsigned N_FAN  = 2,
  parameter int unsigned FAN_W  = 16,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [ADDR_W-1:0]           addr,
  input logic [DATA_W-1:0]           rd_data,
  input logic                        alert_n,
  input logic [N_EXT-1:0]            fault_in,
  input logic [N_MEAS-1:0]           st_meas,
  input logic [N_EXT-1:0]            st_ext,
  input logic [N_MEAS-1:0]           hit_meas,
  input logic                        rd_a_ev,
  input logic                        rd_b_ev,
  input logic [N_FAN-1:0][FAN_W-1:0] fan_lim,
  input logic [N_FAN-1:0]            fan_commit
);
  // R4
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_a_ev) |=> ((st_meas & $past(st_meas)) == $past(st_meas)));

  // R5
  meas_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(st_meas) & ~st_meas)) |-> $past(rd_a_ev));

  // R5
  ext_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(st_ext) & ~st_ext)) |-> ($past(rd_b_ev) &&
                                      ((($past(st_ext) & ~st_ext) & $past(fault_in)) == '0)));

  // R7
  ext_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|fault_in) |=> ((st_ext & $past(fault_in)) == $past(fault_in)));

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_ev && (|hit_meas)) |=> ((st_meas & $past(hit_meas)) == $past(hit_meas)));

  // R6
  summary_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(ADR_STAT_A)) |-> (rd_data[DATA_W-1] == (|st_ext)));

  // R7
  b_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(ADR_STAT_B)) |-> (rd_data[DATA_W-1:N_EXT] == '0));

  // R9
  alert_has_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!alert_n) |-> ((|st_meas) || (|st_ext)));

  // R3
  fan_atomic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(|fan_commit)) |-> $stable(fan_lim));
endmodule

bind limit_alert_ctrl limit_alert_chk #(
  .N_MEAS(N_ANA + N_FAN), .N_EXT(N_EXT), .N_FAN(N_FAN), .FAN_W(FAN_W),
  .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd_data(rd_data),
  .alert_n(alert_n), .fault_in(fault_in), .st_meas(st_meas),
  .st_ext(st_ext), .hit_meas(hit_meas), .rd_a_ev(rd_a_ev),
  .rd_b_ev(rd_b_ev), .fan_lim(fan_lim), .fan_commit(fan_commit)
);

// File: tb/tb_limit_alert_ctrl.sv
`timescale 1ns/1ps
module tb_limit_alert_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, meas_valid = 1'b0;
  logic [4:0]  addr = '0;
  logic [7:0]  wr_data = '0, rd_data;
  logic [2:0]  meas_ch = '0;
  logic [15:0] meas_val = '0;
  logic [5:0]  fault_in = '0;
  logic        alert_n;
  int          n_chk = 0, n_err = 0;
  logic [7:0]  hi_lim [5];
  logic [7:0]  lo_lim [5];
  logic [15:0] fan_l  [2];

  always #2 clk = ~clk;

  limit_alert_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .meas_valid(meas_valid),
    .meas_ch(meas_ch), .meas_val(meas_val), .fault_in(fault_in),
    .alert_n(alert_n));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1; #1 d = rd_data;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic peek(input logic [4:0] a, output logic [7:0] d);
    addr = a; #1 d = rd_data;
  endtask

  task automatic meas(input int ch, input logic [15:0] v);
    meas_ch = 3'(ch); meas_val = v; meas_valid = 1'b1;
    @(negedge clk); meas_valid = 1'b0;
  endtask

  function automatic logic oor(input int ch, input logic [15:0] v);
    if (ch < 5) return (v[7:0] > hi_lim[ch]) || (v[7:0] <= lo_lim[ch]);
    return v > fan_l[ch-5];
  endfunction

  // measure v, check the sticky bit, then prove clear only after fault leaves
  task automatic probe(input int ch, input logic [15:0] v, input logic [15:0] safe);
    logic [7:0] d;
    logic e;
    e = oor(ch, v);
    meas(ch, v);
    peek(5'h00, d);
    chk($sformatf("R1/R2 ch%0d v=%0h bit", ch, v), 32'(d[6-ch]), 32'(e));
    chk("R9 alert level", 32'(alert_n), 32'(!e));
    if (e) begin
      meas(ch, v);
      rd(5'h00, d);
      peek(5'h00, d);
      chk("R5 read with fault present keeps bit", 32'(d[6-ch]), 32'd1);
      meas(ch, safe);
      peek(5'h00, d);
      chk("R4 bit sticky after return", 32'(d[6-ch]), 32'd1);
      rd(5'h00, d);
      peek(5'h00, d);
      chk("R5 read after return clears", 32'(d[6-ch]), 32'd0);
      chk("R9 alert released", 32'(alert_n), 32'd1);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    for (int k = 0; k < 5; k++) begin hi_lim[k] = 8'hFF; lo_lim[k] = 8'h00; end
    fan_l[0] = 16'hFFFF; fan_l[1] = 16'hFFFF;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset values
    peek(5'h00, d); chk("R11 status A", 32'(d), 0);
    peek(5'h01, d); chk("R11 status B", 32'(d), 0);
    peek(5'h02, d); chk("R11 mask A", 32'(d), 0);
    peek(5'h03, d); chk("R11 mask B", 32'(d), 0);
    chk("R11 alert_n", 32'(alert_n), 1);
    for (int k = 0; k < 5; k++) begin
      peek(5'(4+2*k), d); chk("R11 high limit", 32'(d), 32'hFF);
      peek(5'(5+2*k), d); chk("R11 low limit", 32'(d), 0);
    end
    peek(5'h1F, d); chk("R11 unmapped", 32'(d), 0);
    for (int a = 16; a < 20; a++) begin
      peek(5'(a), d); chk("R3 fan reset byte", 32'(d), 32'hFF);
    end
    meas(6, 16'hFFFF);
    peek(5'h00, d); chk("R3 default fan limit FFFF not exceeded", 32'(d), 0);
    meas(7, 16'h0000);
    peek(5'h00, d); chk("R6 channel 7 ignored", 32'(d), 0);

    // analog limits
    for (int k = 0; k < 5; k++) begin
      hi_lim[k] = 8'(8'h90 + k); lo_lim[k] = 8'(8'h30 - k);
      wr(5'(4+2*k), hi_lim[k]); wr(5'(5+2*k), lo_lim[k]);
    end
    for (int v = 0; v < 256; v++) probe(0, {8'hA5, 8'(v)}, 16'h0060);
    for (int k = 1; k < 5; k++) begin
      probe(k, {8'h00, lo_lim[k] - 8'd1}, 16'h60);
      probe(k, {8'h00, lo_lim[k]}, 16'h60);
      probe(k, {8'hFF, lo_lim[k] + 8'd1}, 16'h60);
      probe(k, {8'h00, hi_lim[k]}, 16'h60);
      probe(k, {8'h00, hi_lim[k] + 8'd1}, 16'h60);
      probe(k, 16'h00FF, 16'h60);
    end

    // R3 atomic fan limit
    wr(5'h10, 8'h34);
    peek(5'h10, d); chk("R3 low byte held in shadow", 32'(d), 32'hFF);
    meas(5, 16'h1235);
    peek(5'h00, d); chk("R3 limit unchanged before high byte", 32'(d[1]), 0);
    wr(5'h11, 8'h12); fan_l[0] = 16'h1234;
    peek(5'h10, d); chk("R3 low byte committed", 32'(d), 32'h34);
    peek(5'h11, d); chk("R3 high byte", 32'(d), 32'h12);
    for (int v = 16'h1230; v < 16'h1239; v++) probe(5, 16'(v), 16'h0100);
    probe(5, 16'hFFFF, 16'h0100);
    wr(5'h12, 8'hFF); wr(5'h13, 8'h00); fan_l[1] = 16'h00FF;
    for (int v = 16'h00F8; v < 16'h0108; v++) probe(6, 16'(v), 16'h0010);

    // R7 / R6 external faults
    for (int j = 0; j < 6; j++) begin
      fault_in = 6'(1 << j); @(negedge clk); fault_in = '0;
      peek(5'h01, d); chk("R7 status B bit", 32'(d), 32'(1 << j));
      peek(5'h00, d); chk("R6 summary set", 32'(d), 32'h80);
      chk("R9 alert from fault", 32'(alert_n), 0);
      fault_in = 6'(1 << j);
      rd(5'h01, d); chk("R5 read returns pre-clear", 32'(d), 32'(1 << j));
      fault_in = '0;
      peek(5'h01, d); chk("R5 held while fault high", 32'(d), 32'(1 << j));
      rd(5'h01, d);
      peek(5'h01, d); chk("R5 cleared after fault low", 32'(d), 0);
      peek(5'h00, d); chk("R6 summary clear", 32'(d), 0);
    end

    // R8 masks
    wr(5'h02, 8'h40);
    peek(5'h02, d); chk("R8 mask A readback", 32'(d), 32'h40);
    meas(0, 16'h00FF);
    peek(5'h00, d); chk("R8 masked source sets status", 32'(d), 32'h40);
    chk("R8 masked source no alert", 32'(alert_n), 1);
    wr(5'h02, 8'h00);
    chk("R9 unmasking exposes sticky bit", 32'(alert_n), 0);
    meas(0, 16'h0060); rd(5'h00, d);
    wr(5'h03, 8'h04);
    fault_in = 6'h04; @(negedge clk); fault_in = '0;
    peek(5'h01, d); chk("R8 masked fault sets status", 32'(d), 32'h04);
    chk("R8 masked fault no alert", 32'(alert_n), 1);
    rd(5'h01, d); wr(5'h03, 8'h00);

    // R10 set wins against simultaneous read
    addr = 5'h00; rd_en = 1'b1; meas_ch = 3'd1; meas_val = 16'h00FF; meas_valid = 1'b1;
    @(negedge clk); rd_en = 1'b0; meas_valid = 1'b0;
    peek(5'h00, d); chk("R10 set wins over read", 32'(d), 32'h20);
    meas(1, 16'h0060); rd(5'h00, d);

    // R9 two sources, alert held until both cleared
    meas(2, 16'h00FF);
    fault_in = 6'h01; @(negedge clk); fault_in = '0;
    meas(2, 16'h0060); rd(5'h00, d);
    chk("R9 alert held by remaining source", 32'(alert_n), 0);
    rd(5'h01, d);
    chk("R9 alert released after last clear", 32'(alert_n), 1);
    peek(5'h00, d); chk("R4 all clear at end", 32'(d), 0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule